// File: doc/BRIEF.md
# General-Purpose Pin Port with Conversion Busy Flag

This block is one register of a small register file reached over a serial control link. It occupies a single register address and holds the state of a few bidirectional general-purpose pins. A direction mask comes from a neighbouring control register and marks each pin as an input or an output. A pin marked as an output drives the level last written to it. A pin marked as an input ignores writes, and its bit in a read returns the level on the pin after that level has passed through a synchroniser.

The same register also carries the trigger and status bit of the analogue conversion engine. Writing a one to the top bit sends a single-cycle start pulse to the engine. Reading that bit reports whether a conversion is in progress. The serial transport that produces the read and write strobes lies outside this block, and so does the conversion engine.

All outputs are registered. The direction mask reaches the pad drivers one clock after it is applied. Read data is captured on the clock edge of the read strobe and holds until the next read strobe.

Top module: `dio_busy_port`

## Requirements
- R1: While reset is high and after it falls, `reg_rdata`, `pin_out`, `pin_oe` and `conv_start` are all 0, and every pin is an input with a stored output level of 0.
- R2: `pin_oe` equals the `dir_oe` value that was present at the previous clock edge.
- R3: A write (`reg_wr`=1) to address 5 stores `reg_wdata[i]` for every pin i whose `dir_oe[i]` is 1, and the new level appears on `pin_out[i]` after that edge.
- R4: A write to address 5 leaves the stored level of every pin whose `dir_oe[i]` is 0 unchanged. This shows on `pin_out[i]`, and in a later read once the pin is switched to an output.
- R5: A read (`reg_rd`=1) of address 5 returns the stored output level in bit i for every pin whose `dir_oe[i]` is 1.
- R6: For every pin whose `dir_oe[i]` is 0, a read returns the level on `pin_in[i]` two clock edges before the read edge. A level applied before edge k first appears in a read strobed at edge k+2. A read strobed at edge k+1 still returns the previous level.
- R7: A write to address 5 with `reg_wdata[7]`=1 makes `conv_start` high for exactly the one cycle after that edge. A write with bit 7 at 0, or a write to any other address, gives no pulse.
- R8: Bit 7 of a read of address 5 is 1 when `conv_busy` is 1 or `conv_start` is 1 at the read edge, and 0 otherwise.
- R9: Bits 6:4 of every read are 0. A read of any other address returns 0. `reg_rdata` changes only on an edge where `reg_rd` is 1.
- R10: A write to any address other than 5 leaves `pin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address of the current access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| dir_oe | input | 4 | Direction mask from the neighbouring control register, 1 = output |
| pin_in | input | 4 | Asynchronous levels on the pins |
| pin_out | output | 4 | Levels driven on the pins |
| pin_oe | output | 4 | Per-pin output enable to the pad drivers |
| conv_busy | input | 1 | Conversion engine reports that a conversion is running |
| conv_start | output | 1 | Single-cycle conversion start request |

## Verification
The hardest case to reach from the ports is a level written to a pin while that pin is an input. The write must be ignored, and the effect only shows once the pin later becomes an output. The bench drives every direction mask against every write pattern in sequence. It keeps an arithmetic model of the stored levels, so each iteration can expose a wrongly captured bit from an earlier one. A second hard case is a read strobed in the cycle right after a start write: bit 7 must already read one before the engine raises its busy flag. This is reached by putting a read immediately after the start write.

// File: rtl/dio_pkg.sv
package dio_pkg;

  // Width of the register data bus shared by the whole register file.
  localparam int REG_W = 8;

  // Decoded access kind for one cycle.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  function automatic acc_e classify(input logic wr, input logic rd);
    if (wr)      return ACC_WRITE;
    else if (rd) return ACC_READ;
    else         return ACC_IDLE;
  endfunction

endpackage

// File: rtl/dio_sync.sv
// Multi-stage synchroniser for asynchronous pin levels.
module dio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/dio_pin_cell.sv
// One pin: stored output level (written only while an output) and
// registered pad enable.
module dio_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic dir,
  input  logic wbit,
  output logic level_q,
  output logic oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= dir;
      if (wr_hit && dir) level_q <= wbit;
    end
  end

endmodule

// File: rtl/dio_readback.sv
// Builds the read word and registers it on each read strobe.
module dio_readback #(
  parameter int N        = 4,
  parameter int DATA_W   = 8,
  parameter int BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              hit,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0]      level,
  input  logic [N-1:0]      sampled,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < N; i++) begin
      word[i] = dir[i] ? level[i] : sampled[i];
    end
    word[BUSY_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit ? word : '0;
  end

endmodule

// File: rtl/dio_busy_port.sv
module dio_busy_port #(
  parameter int N           = 4,
  parameter int ADDR_W      = 3,
  parameter int PORT_ADDR   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_BIT    = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [dio_pkg::REG_W-1:0] reg_wdata,
  output logic [dio_pkg::REG_W-1:0] reg_rdata,
  input  logic [N-1:0]             dir_oe,
  input  logic [N-1:0]             pin_in,
  output logic [N-1:0]             pin_out,
  output logic [N-1:0]             pin_oe,
  input  logic                     conv_busy,
  output logic                     conv_start
);

  import dio_pkg::*;

  localparam int DATA_W = REG_W;
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  initial begin
    if (N >= BUSY_BIT || BUSY_BIT >= DATA_W)
      $error("dio_busy_port: pins must sit below the busy bit inside the word");
  end

  acc_e acc;
  logic hit, wr_hit, rd_hit;
  logic [N-1:0] sampled;
  logic [N-1:0] level;
  logic start_q;

  assign acc    = classify(reg_wr, reg_rd);
  assign hit    = (reg_addr == MY_ADDR);
  assign wr_hit = hit && (acc == ACC_WRITE);
  assign rd_hit = hit && reg_rd;

  dio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (sampled)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      dio_pin_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .dir     (dir_oe[i]),
        .wbit    (reg_wdata[i]),
        .level_q (level[i]),
        .oe_q    (pin_oe[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= wr_hit && reg_wdata[BUSY_BIT];
  end

  dio_readback #(.N(N), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd      (reg_rd),
    .hit     (rd_hit),
    .dir     (dir_oe),
    .level   (level),
    .sampled (sampled),
    .busy    (conv_busy | start_q),
    .rdata   (reg_rdata)
  );

  assign pin_out    = level;
  assign conv_start = start_q;

endmodule

// File: rtl/dio_busy_port_chk.sv
module dio_busy_port_chk #(
  parameter int N           = 4,
  parameter int ADDR_W      = 3,
  parameter int PORT_ADDR   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_BIT    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [N-1:0]      dir_oe,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe,
  input logic              conv_start
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  AST_OE_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe == $past(dir_oe)); // R2

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && conv_start) |->
      $past(reg_wr && reg_addr == MY_ADDR && reg_wdata[BUSY_BIT])); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[BUSY_BIT-1:N] == '0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rd)) |-> $stable(reg_rdata)); // R9

  AST_OTHER_ADDR_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_wr && reg_addr == MY_ADDR)) |-> $stable(pin_out)); // R10

  generate
    for (genvar i = 0; i < N; i++) begin : g_in
      AST_INPUT_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(dir_oe[i])) |-> pin_out[i] == $past(pin_out[i])); // R4
    end
  endgenerate

endmodule

bind dio_busy_port dio_busy_port_chk #(
  .N(N), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR),
  .SYNC_STAGES(SYNC_STAGES), .BUSY_BIT(BUSY_BIT)
) u_chk (.*);

// File: tb/dio_busy_port_test.sv
module dio_busy_port_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] dir_oe, pin_in, pin_out, pin_oe;
  logic       conv_busy, conv_start;

  int checks = 0;
  int errors = 0;
  logic [3:0] model;  // expected stored output levels

  always #2 clk = ~clk;  // 250 MHz

  dio_busy_port uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_oe(dir_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .conv_busy(conv_busy), .conv_start(conv_start)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Each task drives at a falling edge and returns at the falling edge after
  // the rising edge that consumed the access.
  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    dir_oe = '0; pin_in = '0; conv_busy = 0;
    model = '0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk("R1", reg_rdata, 8'h00);
    chk("R1", {conv_start, 3'b0, pin_out}, 8'h00);
    chk("R1", {4'h0, pin_oe}, 8'h00);
    rst = 1'b0;
    idle();
    chk("R1", {conv_start, 3'b0, pin_oe, pin_out} >> 0, 8'h00);

    // Exhaustive sweep: every direction mask against every write nibble.
    for (int oe = 0; oe < 16; oe++) begin
      for (int w = 0; w < 16; w++) begin
        logic [3:0] pat;
        logic [7:0] rexp;
        pat = 4'((w * 5 + oe * 3 + 7) & 15);
        dir_oe = 4'(oe);
        pin_in = pat;
        do_write(3'd5, 8'(w));                         // edge 1
        model = (model & ~4'(oe)) | (4'(w) & 4'(oe));
        chk("R3/R4", {4'h0, pin_out}, {4'h0, model});
        chk("R2", {4'h0, pin_oe}, 8'(oe));
        chk("R7", {7'h0, conv_start}, 8'h00);
        idle();                                         // edge 2
        do_read(3'd5);                                  // edge 3
        rexp = {4'h0, (model & 4'(oe)) | (pat & ~4'(oe))};
        chk("R5/R6", reg_rdata, rexp);
      end
    end

    // R4: write while input, then switch to output: stored level is old.
    dir_oe = 4'h0;
    do_write(3'd5, 8'h0F);
    chk("R4", {4'h0, pin_out}, {4'h0, model});
    dir_oe = 4'hF;
    idle();
    do_read(3'd5);
    chk("R4", reg_rdata, {4'h0, model});

    // R6: a level applied before edge k is seen by a read at edge k+2 only.
    dir_oe = 4'h0;
    pin_in = 4'h0;
    idle(); idle(); idle();
    pin_in = 4'hA;
    idle();                    // edge k
    do_read(3'd5);             // edge k+1
    chk("R6", reg_rdata, 8'h00);
    do_read(3'd5);             // edge k+2
    chk("R6", reg_rdata, 8'h0A);

    // R7 and R8: start pulse, its single-cycle width, and busy readback.
    conv_busy = 1'b0;
    do_write(3'd5, 8'h80);
    chk("R7", {7'h0, conv_start}, 8'h01);
    do_read(3'd5);
    chk("R7", {7'h0, conv_start}, 8'h00);
    chk("R8", {reg_rdata[7], 7'h0}, 8'h80);
    do_read(3'd5);
    chk("R8", {reg_rdata[7], 7'h0}, 8'h00);
    conv_busy = 1'b1;
    do_read(3'd5);
    chk("R8", {reg_rdata[7], 7'h0}, 8'h80);
    conv_busy = 1'b0;
    do_write(3'd5, 8'h00);
    chk("R7", {7'h0, conv_start}, 8'h00);
    model = 4'h0;

    // R9 and R10: other addresses, and reserved bits.
    dir_oe = 4'hF;
    do_write(3'd5, 8'h75);
    model = 4'h5;
    for (int a = 0; a < 8; a++) begin
      if (a != 5) begin
        do_write(3'(a), 8'hFA);
        chk("R10", {4'h0, pin_out}, {4'h0, model});
        chk("R7", {7'h0, conv_start}, 8'h00);
        conv_busy = 1'b1;
        do_read(3'(a));
        chk("R9", reg_rdata, 8'h00);
        conv_busy = 1'b0;
      end
    end
    do_read(3'd5);
    chk("R9", reg_rdata, 8'h05);
    idle(); idle();
    chk("R9", reg_rdata, 8'h05);

    // R1: reset mid-run clears everything.
    rst = 1'b1;
    idle();
    rst = 1'b0;
    chk("R1", {4'h0, pin_out}, 8'h00);
    chk("R1", reg_rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule